// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns a memory-reference instruction into the 15-bit address of its operand. The instruction carries a 9-bit offset and three modifier flags. The page flag picks the base page for the offset: either page zero, or the 512-word page that holds the program counter. The index flag adds an index value that the surrounding processor supplies. That value comes from whichever index source the processor has selected; this block does not choose it. The indirect flag makes the resulting address point at a pointer word, which the block reads from memory.

Each pointer word carries its own index and indirect flags and a 14-bit address. That address is widened with the top bit of the program counter, so the target stays in the current 16K half of memory. A pointer word whose indirect flag is set leads to a further read. A parameter caps the number of pointer reads. Instructions whose opcode is not a memory reference skip address formation and are flagged as bypassed.

A request is a one-cycle `start` pulse. The result is reported by a one-cycle `done` pulse, together with `ea`, `err` and `bypass`. The processor holds `instr`, `pc` and `idx` steady from `start` until `done`.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset, `done`, `mem_req`, `err` and `bypass` are 0 and `ea` is 0.
- R2: The opcode is `instr[15:12]`. Opcode values 0, 11 and 15 are not memory references. For these, `done` rises one cycle after `start` with `bypass`=1, `err`=0 and `ea`=0, and no memory read is made.
- R3: The page flag is `instr[9]` and the offset is `instr[8:0]`. With the page flag at 0, the address is {6'b0, offset}. With the page flag at 1, the address is {pc[14:9], offset}.
- R4: The index flag is `instr[11]`. When it is 1, `idx` is added to the paged address modulo 2^15, and this happens before any indirection.
- R5: The indirect flag is `instr[10]`. When it is 0, `done` rises exactly one cycle after `start`, with no memory read and `err`=0.
- R6: When the indirect flag is 1, the indexed address is read. The pointer word returned has `[15]` as its index flag, `[14]` as its indirect flag and `[13:0]` as its address. Its target is {pc[14], word[13:0]}, plus `idx` modulo 2^15 when `word[15]` is 1.
- R7: A pointer word whose indirect flag is 0 ends the chain, and its target is reported on `ea` with `done`. A pointer word whose indirect flag is 1 causes its target to be read next.
- R8: At most MAX_LEVELS (default 4) pointer words are read. A chain of exactly MAX_LEVELS reads ends normally. If the MAX_LEVELS-th word still has its indirect flag set, `done` rises with `err`=1 and `ea` equal to that word's target.
- R9: `mem_req` is held, with `mem_addr` unchanged, until a cycle in which `mem_ack` is 1. `mem_rdata` is taken in that cycle. The response may be delayed by any number of cycles.
- R10: `done` is a single-cycle pulse. `start` is ignored while an address is being formed, and `mem_req` is never high while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin forming an address for `instr` |
| instr | input | 16 | Instruction word |
| pc | input | 15 | Program counter |
| idx | input | 15 | Index value chosen by the processor |
| mem_req | output | 1 | Pointer-word read request |
| mem_addr | output | 15 | Address of the pointer word being read |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 16 | Pointer word returned |
| ea | output | 15 | Effective address, valid with `done` |
| done | output | 1 | One-cycle completion strobe |
| bypass | output | 1 | Opcode is not a memory reference (with `done`) |
| err | output | 1 | Indirection limit exceeded (with `done`) |

## Verification
The hardest situations to reach from the ports are at the indirection limit. One is a chain that ends on exactly the last permitted read; the other is a chain that loops forever and must be cut off. The bench's memory model holds a pointer word that refers to itself, and a four-deep chain that ends on the fourth word. Both are reached through ordinary instructions, and response delays of zero to three cycles exercise the request-holding rule at every level. A further test keeps `start` high with a different instruction during a slow fetch, to show that this second request is ignored.

// File: rtl/pea_pkg.sv
package pea_pkg;
    localparam int AW     = 15;
    localparam int DW     = 16;
    localparam int OFFW   = 9;
    localparam int PAGEW  = AW - OFFW;
    localparam int IND_AW = 14;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] word_t;

    // instruction layout, most significant field first
    typedef struct packed {
        logic [3:0]      op;
        logic            xflag;
        logic            iflag;
        logic            pflag;
        logic [OFFW-1:0] off;
    } mr_instr_t;

    typedef struct packed {
        logic              xflag;
        logic              iflag;
        logic [IND_AW-1:0] adr;
    } ind_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DONE
    } state_t;

    function automatic logic is_memref(logic [3:0] op);
        return !(op == 4'o00 || op == 4'o13 || op == 4'o17);
    endfunction

    function automatic addr_t page_base(mr_instr_t ins, addr_t pc);
        return ins.pflag ? {pc[AW-1:OFFW], ins.off} : {{PAGEW{1'b0}}, ins.off};
    endfunction

    function automatic addr_t ind_base(ind_word_t w, addr_t pc);
        return {pc[AW-1], w.adr};
    endfunction

    function automatic addr_t add_idx(addr_t base, addr_t idx, logic en);
        return en ? addr_t'(base + idx) : base;
    endfunction
endpackage

// File: rtl/pea_form.sv
module pea_form
    import pea_pkg::*;
(
    input  word_t instr,
    input  addr_t pc,
    input  addr_t idx,
    input  word_t rdata,
    output logic  memref,
    output logic  first_ind,
    output addr_t first_addr,
    output logic  next_ind,
    output addr_t next_addr
);
    mr_instr_t ins;
    ind_word_t pw;

    always_comb begin
        ins        = mr_instr_t'(instr);
        pw         = ind_word_t'(rdata);
        memref     = is_memref(ins.op);
        first_ind  = ins.iflag;
        // page first, then index
        first_addr = add_idx(page_base(ins, pc), idx, ins.xflag);
        next_ind   = pw.iflag;
        next_addr  = add_idx(ind_base(pw, pc), idx, pw.xflag);
    end
endmodule

// File: rtl/pea_seq.sv
module pea_seq
    import pea_pkg::*;
#(
    parameter int MAX_LEVELS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  memref,
    input  logic  first_ind,
    input  addr_t first_addr,
    input  logic  mem_ack,
    input  logic  next_ind,
    input  addr_t next_addr,
    output logic  mem_req,
    output addr_t mem_addr,
    output addr_t ea,
    output logic  done,
    output logic  bypass,
    output logic  err
);
    localparam int LVW = $clog2(MAX_LEVELS + 1);
    localparam logic [LVW-1:0] LV_LAST = LVW'(MAX_LEVELS - 1);

    state_t         state;
    addr_t          ptr;
    addr_t          ea_q;
    logic           err_q;
    logic           byp_q;
    logic [LVW-1:0] lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr   <= '0;
            ea_q  <= '0;
            err_q <= 1'b0;
            byp_q <= 1'b0;
            lvl   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lvl   <= '0;
                        err_q <= 1'b0;
                        if (!memref) begin
                            byp_q <= 1'b1;
                            ea_q  <= '0;
                            state <= ST_DONE;
                        end else begin
                            byp_q <= 1'b0;
                            if (first_ind) begin
                                ptr   <= first_addr;
                                state <= ST_FETCH;
                            end else begin
                                ea_q  <= first_addr;
                                state <= ST_DONE;
                            end
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        lvl <= lvl + 1'b1;
                        if (!next_ind) begin
                            ea_q  <= next_addr;
                            state <= ST_DONE;
                        end else if (lvl == LV_LAST) begin
                            ea_q  <= next_addr;
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            ptr <= next_addr;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done     = (state == ST_DONE);
    assign mem_req  = (state == ST_FETCH);
    assign mem_addr = ptr;
    assign ea       = ea_q;
    assign err      = done & err_q;
    assign bypass   = done & byp_q;
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
    parameter int MAX_LEVELS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] instr,
    input  logic [14:0] pc,
    input  logic [14:0] idx,
    output logic        mem_req,
    output logic [14:0] mem_addr,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata,
    output logic [14:0] ea,
    output logic        done,
    output logic        bypass,
    output logic        err
);
    import pea_pkg::*;

    logic  memref;
    logic  first_ind;
    addr_t first_addr;
    logic  next_ind;
    addr_t next_addr;

    pea_form u_form (
        .instr      (instr),
        .pc         (pc),
        .idx        (idx),
        .rdata      (mem_rdata),
        .memref     (memref),
        .first_ind  (first_ind),
        .first_addr (first_addr),
        .next_ind   (next_ind),
        .next_addr  (next_addr)
    );

    pea_seq #(.MAX_LEVELS(MAX_LEVELS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .memref     (memref),
        .first_ind  (first_ind),
        .first_addr (first_addr),
        .mem_ack    (mem_ack),
        .next_ind   (next_ind),
        .next_addr  (next_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .ea         (ea),
        .done       (done),
        .bypass     (bypass),
        .err        (err)
    );
endmodule

// File: rtl/pea_checker.sv
module pea_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [15:0] instr,
    input logic [14:0] pc,
    input logic [14:0] idx,
    input logic        mem_req,
    input logic [14:0] mem_addr,
    input logic        mem_ack,
    input logic [15:0] mem_rdata,
    input logic [14:0] ea,
    input logic        done,
    input logic        bypass,
    input logic        err
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !mem_req && !err && !bypass));

    assert_bypass_zero_ea_R2: assert property (@(posedge clk) disable iff (rst)
        (done && bypass) |-> (ea == 15'd0 && !err));

    assert_req_from_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(start));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_no_req_at_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);
endmodule

bind paged_ea_gen pea_checker u_chk (.*);

// File: tb/paged_ea_gen_tb.sv
module paged_ea_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [14:0] pc = '0;
    logic [14:0] idx = '0;
    logic        mem_req;
    logic [14:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [14:0] ea;
    logic        done;
    logic        bypass;
    logic        err;

    int n_tests = 0;
    int n_fail  = 0;
    int fetches = 0;
    int wcnt    = 0;
    logic [1:0] lat = 2'd0;

    always #5 clk = ~clk;

    paged_ea_gen u_dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc(pc), .idx(idx),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .ea(ea), .done(done), .bypass(bypass), .err(err)
    );

    function automatic logic [15:0] mem_word(logic [14:0] a);
        case (a)
            15'h0010: return 16'h0123;
            15'h0020: return 16'h4030;
            15'h0030: return 16'h8100;
            15'h0040: return 16'h4040;
            15'h0050: return 16'h4051;
            15'h0051: return 16'h4052;
            15'h0052: return 16'h0777;
            15'h0060: return 16'h4061;
            15'h0061: return 16'h4062;
            15'h0062: return 16'h4063;
            15'h0063: return 16'h0ABC;
            default:  return 16'h0000;
        endcase
    endfunction

    // memory responder with selectable delay
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt == int'(lat)) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_word(mem_addr);
                wcnt      <= 0;
                fetches   <= fetches + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    logic [14:0] r_ea;
    logic        r_err, r_byp;
    int          r_nf, r_cyc, r_after;

    task automatic run(logic [15:0] ins, logic [14:0] p, logic [14:0] x,
                       logic [1:0] l, logic hold_other);
        int f0;
        @(negedge clk);
        instr = ins; pc = p; idx = x; lat = l;
        f0 = fetches;
        start = 1'b1;
        @(negedge clk);
        if (hold_other) instr = 16'h11FF;
        else start = 1'b0;
        r_cyc = 1;
        while (!done && r_cyc < 200) begin
            @(negedge clk);
            r_cyc++;
        end
        start = 1'b0;
        r_ea = ea; r_err = err; r_byp = bypass; r_nf = fetches - f0;
        @(negedge clk);
        r_after = int'(done);
    endtask

    typedef struct packed {
        logic [15:0] ins;
        logic [14:0] pc;
        logic [14:0] idx;
        logic [1:0]  lat;
        logic [14:0] ea;
        logic        err;
        logic [3:0]  nf;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{16'h11FF, 15'h7C00, 15'h0000, 2'd0, 15'h01FF, 1'b0, 4'd0}, // R3 page 0
        '{16'h1205, 15'h1A37, 15'h0000, 2'd0, 15'h1A05, 1'b0, 4'd0}, // R3 current page
        '{16'h1810, 15'h0000, 15'h0100, 2'd0, 15'h0110, 1'b0, 4'd0}, // R4 index
        '{16'h1BFF, 15'h7E00, 15'h0001, 2'd0, 15'h0000, 1'b0, 4'd0}, // R4 wrap
        '{16'h1410, 15'h0000, 15'h0000, 2'd0, 15'h0123, 1'b0, 4'd1}, // R6 one level
        '{16'h1C08, 15'h0000, 15'h0008, 2'd2, 15'h0123, 1'b0, 4'd1}, // R4 index before R6
        '{16'h1410, 15'h4000, 15'h0000, 2'd1, 15'h4123, 1'b0, 4'd1}, // R6 pc top bit
        '{16'h1420, 15'h0000, 15'h0007, 2'd1, 15'h0107, 1'b0, 4'd2}, // R7 two levels
        '{16'h1450, 15'h0000, 15'h0000, 2'd0, 15'h0777, 1'b0, 4'd3}, // R7 three levels
        '{16'h1460, 15'h0000, 15'h0000, 2'd3, 15'h0ABC, 1'b0, 4'd4}, // R8 exact limit
        '{16'h1440, 15'h0000, 15'h0000, 2'd0, 15'h0040, 1'b1, 4'd4}, // R8 overrun
        '{16'h1430, 15'h4000, 15'h7F00, 2'd1, 15'h4000, 1'b0, 4'd1}  // R6 post-index wrap
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", 32'(done), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 ea", 32'(ea), 0);
        check("R1 err/bypass", 32'({err, bypass}), 0);
        rst = 1'b0;

        foreach (VECS[i]) begin
            run(VECS[i].ins, VECS[i].pc, VECS[i].idx, VECS[i].lat, 1'b0);
            check($sformatf("R3/R4/R6/R7/R8 vec%0d ea", i), 32'(r_ea), 32'(VECS[i].ea));
            check($sformatf("R8 vec%0d err", i), 32'(r_err), 32'(VECS[i].err));
            check($sformatf("R9 vec%0d fetches", i), r_nf, 32'(VECS[i].nf));
            check($sformatf("R10 vec%0d pulse", i), r_after, 0);
        end

        // R5 direct address: one cycle, no read
        run(16'h1205, 15'h1A37, 15'h0000, 2'd0, 1'b0);
        check("R5 latency", r_cyc, 1);
        check("R5 no read", r_nf, 0);
        check("R5 bypass low", 32'(r_byp), 0);

        // R2 opcodes 0, 11, 15 bypass
        run(16'h0410, 15'h1A37, 15'h0001, 2'd0, 1'b0);
        check("R2 op0 bypass", 32'(r_byp), 1);
        check("R2 op0 ea", 32'(r_ea), 0);
        check("R2 op0 no read", r_nf, 0);
        check("R2 op0 latency", r_cyc, 1);
        run(16'hB410, 15'h0000, 15'h0000, 2'd0, 1'b0);
        check("R2 op11 bypass", 32'({r_byp, r_err}), 32'b10);
        check("R2 op11 no read", r_nf, 0);
        run(16'hF9FF, 15'h0000, 15'h0000, 2'd0, 1'b0);
        check("R2 op15 bypass", 32'(r_byp), 1);
        check("R2 op15 ea", 32'(r_ea), 0);
        run(16'h2410, 15'h0000, 15'h0000, 2'd0, 1'b0);
        check("R2 op2 is memref", 32'({r_byp, r_ea}), 32'h0123);

        // R10 start held with another instruction during a slow fetch
        run(16'h1420, 15'h0000, 15'h0007, 2'd3, 1'b1);
        check("R10 start ignored ea", 32'(r_ea), 32'h0107);
        check("R10 start ignored fetches", r_nf, 2);
        check("R10 single pulse", r_after, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule